// File: doc/BRIEF.md
# USB Host Status and Interrupt Register

This block is the status register of a full-speed USB host controller. The schedule engine reports events as single-cycle pulses: a descriptor completed (with its completion qualifiers), resume signalling was seen on the bus, the system bus access failed, a descriptor failed its consistency check, and whether the engine is idle. The block turns these pulses into sticky status flags. Software clears each flag by writing a one to it. The block also drives a single interrupt line.

The block also holds the controller's run/stop control. Software loads it through a command-write input. Either fatal error clears it. While run/stop is clear and the engine is idle, the halted flag is raised. A separate level input carries the global-suspend state from the command register, and resume signalling is recorded only while that level is high. Reads are combinational from the current flag state.

Top module: `usb_host_status`

## Requirements
- R1: After reset `reg_rd_data` is 0x0020 (only the halted flag, bit 5, is set), `run_stop` is 0 and `irq` is 0.
- R2: Bits 15..6 of `reg_rd_data` always read 0. Writing ones to them changes nothing that is visible.
- R3: Each of bits 5..0 is cleared by a register write with a 1 in that position. A 0 in a written position leaves that bit unchanged.
- R4: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: The halted flag (bit 5) is set in the cycle after an edge at which `run_stop` was 0 and `core_idle` was 1. If it is cleared while `run_stop` is 1, it stays clear.
- R6: A `desc_fault` pulse sets the process-error flag (bit 4) and forces `run_stop` to 0 on the same edge.
- R7: A `sysbus_fault` pulse sets the host-system-error flag (bit 3) and forces `run_stop` to 0 on the same edge.
- R8: A `resume_seen` pulse sets the resume flag (bit 2) only while `cmd_gsusp` is 1. Otherwise the pulse is ignored.
- R9: `td_done` together with `td_err` sets the error-interrupt flag (bit 1). If `td_ioc` is also high, bits 1 and 0 are both set on the same edge.
- R10: `td_done` sets the transfer flag (bit 0) when `td_ioc` is high, or when both `td_short` and `td_spd` are high. A short packet without `td_spd` sets nothing.
- R11: `irq` is the OR of bits 4..0, with bit 0 gated by `ien_xfer`, bit 1 by `ien_err` and bit 2 by `ien_resume`. Bits 4 and 3 are never masked.
- R12: `cmd_wr` loads `run_stop` from `cmd_run`. A fatal pulse in the same cycle wins and leaves `run_stop` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | REG_W | Write data; a 1 in a position clears that flag |
| reg_rd_data | output | REG_W | Current status value |
| cmd_wr | input | 1 | Command write strobe for run/stop |
| cmd_run | input | 1 | Run/stop value loaded on `cmd_wr` |
| cmd_gsusp | input | 1 | Global-suspend level from the command register |
| td_done | input | 1 | A descriptor completed this cycle |
| td_ioc | input | 1 | The completed descriptor requests an interrupt on completion |
| td_err | input | 1 | The completed transaction ended in error |
| td_short | input | 1 | Actual length below maximum length |
| td_spd | input | 1 | Short packet detection is enabled in the descriptor |
| resume_seen | input | 1 | Resume signalling was received |
| sysbus_fault | input | 1 | A system bus access failed |
| desc_fault | input | 1 | A descriptor failed its consistency check |
| core_idle | input | 1 | The schedule engine has stopped processing |
| ien_xfer | input | 1 | Interrupt enable for bit 0 |
| ien_err | input | 1 | Interrupt enable for bit 1 |
| ien_resume | input | 1 | Interrupt enable for bit 2 |
| run_stop | output | 1 | Run/stop control to the schedule engine |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with `REG_W` = 16 and `IRQ_REG` = 0. With these values the reserved upper field is ten bits wide, so writes of all ones exercise it. The interrupt line then follows the flags in the same cycle, which lets the enable masking be compared edge by edge against the reference model. The stimulus drives the hard cases on one edge each: a fatal error coinciding with a command write of 1, a clear coinciding with a set, and completion flags in combination.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   localparam int unsigned NUM_FLAGS = 6;
   localparam int unsigned B_XFER = 0;
   localparam int unsigned B_ERR  = 1;
   localparam int unsigned B_RSM  = 2;
   localparam int unsigned B_HSE  = 3;
   localparam int unsigned B_HPE  = 4;
   localparam int unsigned B_HALT = 5;
   localparam logic [NUM_FLAGS-1:0] FLAG_RESET = 6'b10_0000;
   localparam logic [NUM_FLAGS-2:0] ALWAYS_ON  = 5'b1_1000;

   typedef struct packed {
      logic done;
      logic ioc;
      logic err;
      logic short_pkt;
      logic spd;
   } td_evt_t;
endpackage

// File: rtl/hcs_w1c_bit.sv
module hcs_w1c_bit #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RESET_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/hcs_run_ctrl.sv
module hcs_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic cmd_run,
   input  logic fatal_i,
   output logic run_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_o <= 1'b0;
      else if (fatal_i) run_o <= 1'b0;
      else if (cmd_wr)  run_o <= cmd_run;
   end
endmodule

// File: rtl/hcs_event_decode.sv
module hcs_event_decode
   import hcs_pkg::*;
(
   input  td_evt_t              td,
   input  logic                 resume_seen,
   input  logic                 gsusp,
   input  logic                 sysbus_fault,
   input  logic                 desc_fault,
   input  logic                 run,
   input  logic                 core_idle,
   output logic [NUM_FLAGS-1:0] set_o,
   output logic                 fatal_o
);
   always_comb begin
      set_o         = '0;
      set_o[B_XFER] = td.done && (td.ioc || (td.short_pkt && td.spd));
      set_o[B_ERR]  = td.done && td.err;
      set_o[B_RSM]  = resume_seen && gsusp;
      set_o[B_HSE]  = sysbus_fault;
      set_o[B_HPE]  = desc_fault;
      set_o[B_HALT] = !run && core_idle;
      fatal_o       = sysbus_fault || desc_fault;
   end
endmodule

// File: rtl/hcs_irq_gate.sv
module hcs_irq_gate
   import hcs_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-2:0] flags,
   input  logic [NUM_FLAGS-2:0] enables,
   output logic                 irq_o
);
   logic any_c;
   assign any_c = |(flags & (enables | ALWAYS_ON));

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_c;
      end
   end else begin : g_comb
      assign irq_o = any_c;
   end
endmodule

// File: rtl/usb_host_status.sv
module usb_host_status
   import hcs_pkg::*;
#(
   parameter int unsigned REG_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             cmd_wr,
   input  logic             cmd_run,
   input  logic             cmd_gsusp,
   input  logic             td_done,
   input  logic             td_ioc,
   input  logic             td_err,
   input  logic             td_short,
   input  logic             td_spd,
   input  logic             resume_seen,
   input  logic             sysbus_fault,
   input  logic             desc_fault,
   input  logic             core_idle,
   input  logic             ien_xfer,
   input  logic             ien_err,
   input  logic             ien_resume,
   output logic             run_stop,
   output logic             irq
);
   localparam int unsigned PAD_W = REG_W - NUM_FLAGS;

   if (REG_W < NUM_FLAGS) begin : g_bad_width
      $error("usb_host_status: REG_W must hold all %0d flags", NUM_FLAGS);
   end

   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic                 fatal;
   td_evt_t              td;

   assign td    = '{done: td_done, ioc: td_ioc, err: td_err,
                    short_pkt: td_short, spd: td_spd};
   assign clr_v = reg_wr_en ? reg_wr_data[NUM_FLAGS-1:0] : '0;

   hcs_event_decode u_dec (
      .td           (td),
      .resume_seen  (resume_seen),
      .gsusp        (cmd_gsusp),
      .sysbus_fault (sysbus_fault),
      .desc_fault   (desc_fault),
      .run          (run_stop),
      .core_idle    (core_idle),
      .set_o        (set_v),
      .fatal_o      (fatal)
   );

   hcs_run_ctrl u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_wr  (cmd_wr),
      .cmd_run (cmd_run),
      .fatal_i (fatal),
      .run_o   (run_stop)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      hcs_w1c_bit #(.RESET_VAL(FLAG_RESET[i])) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[i]),
         .clr_i (clr_v[i]),
         .q_o   (flag_q[i])
      );
   end

   if (PAD_W > 0) begin : g_pad
      assign reg_rd_data = {{PAD_W{1'b0}}, flag_q};
   end else begin : g_nopad
      assign reg_rd_data = flag_q;
   end

   hcs_irq_gate #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flag_q[NUM_FLAGS-2:0]),
      .enables ({2'b00, ien_resume, ien_err, ien_xfer}),
      .irq_o   (irq)
   );
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
   parameter int unsigned REG_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] rd,
   input logic             run_stop,
   input logic             irq,
   input logic             gsusp,
   input logic             resume_seen,
   input logic             sysbus_fault,
   input logic             desc_fault,
   input logic             td_done,
   input logic             td_err,
   input logic             core_idle
);
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd[REG_W-1:6] == '0);

   p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (td_done && td_err) |=> rd[1]);

   p_halt_follows_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_stop && core_idle) |=> rd[5]);

   p_desc_fault_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_fault |=> (!run_stop && rd[4]));

   p_bus_fault_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sysbus_fault |=> (!run_stop && rd[3]));

   p_resume_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd[2] && !(resume_seen && gsusp)) |=> !rd[2]);

   if (!IRQ_REG) begin : g_irq_chk
      p_fatal_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (rd[4] || rd[3]) |-> irq);
   end
endmodule

bind usb_host_status hcs_checker #(.REG_W(REG_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd           (reg_rd_data),
   .run_stop     (run_stop),
   .irq          (irq),
   .gsusp        (cmd_gsusp),
   .resume_seen  (resume_seen),
   .sysbus_fault (sysbus_fault),
   .desc_fault   (desc_fault),
   .td_done      (td_done),
   .td_err       (td_err),
   .core_idle    (core_idle)
);

// File: tb/sim_usb_host_status.sv
`timescale 1ns/1ps
module sim_usb_host_status;
   localparam int unsigned W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic         reg_wr_en = 0;
   logic [W-1:0] reg_wr_data = '0;
   logic [W-1:0] reg_rd_data;
   logic cmd_wr = 0, cmd_run = 0, cmd_gsusp = 0;
   logic td_done = 0, td_ioc = 0, td_err = 0, td_short = 0, td_spd = 0;
   logic resume_seen = 0, sysbus_fault = 0, desc_fault = 0, core_idle = 0;
   logic ien_xfer = 0, ien_err = 0, ien_resume = 0;
   logic run_stop, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit [5:0] m_st  = 6'b10_0000;
   bit       m_run = 0;

   always #5 clk = ~clk;

   usb_host_status #(.REG_W(W), .IRQ_REG(1'b0)) u0 (.*);

   task automatic check(input string req, input logic [W-1:0] act_rd,
                        input logic act_run, input logic act_irq);
      logic [W-1:0] exp_rd;
      logic exp_irq;
      exp_rd  = {10'd0, m_st};
      exp_irq = |(m_st[4:0] & {1'b1, 1'b1, ien_resume, ien_err, ien_xfer});
      checks++;
      if (act_rd !== exp_rd || act_run !== m_run || act_irq !== exp_irq) begin
         fails++;
         $display("FAIL %s: rd=%h run=%b irq=%b expected rd=%h run=%b irq=%b",
                  req, act_rd, act_run, act_irq, exp_rd, m_run, exp_irq);
      end
   endtask

   // Behavioural model: advance one edge using the inputs that were held.
   task automatic model_edge();
      bit [5:0] s;
      bit [5:0] c;
      bit fatal;
      fatal = sysbus_fault || desc_fault;
      s = '0;
      if (td_done && (td_ioc || (td_short && td_spd))) s[0] = 1;
      if (td_done && td_err) s[1] = 1;
      if (resume_seen && cmd_gsusp) s[2] = 1;
      if (sysbus_fault) s[3] = 1;
      if (desc_fault) s[4] = 1;
      if (!m_run && core_idle) s[5] = 1;
      c = reg_wr_en ? reg_wr_data[5:0] : 6'd0;
      m_st = s | (m_st & ~c);
      if (fatal) m_run = 0;
      else if (cmd_wr) m_run = cmd_run;
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      model_edge();
      #1;
      check(req, reg_rd_data, run_stop, irq);
      @(negedge clk);
      reg_wr_en = 0; cmd_wr = 0; td_done = 0; td_ioc = 0; td_err = 0;
      td_short = 0; td_spd = 0; resume_seen = 0; sysbus_fault = 0; desc_fault = 0;
   endtask

   task automatic wr(input logic [W-1:0] d);
      reg_wr_en = 1; reg_wr_data = d;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset value", reg_rd_data, run_stop, irq);
      rst_n = 1;
      @(negedge clk);
      // R2 R3: clear everything with an all-ones write, reserved stays zero
      wr(16'hFFFF); tick("R2 R3 all-ones write");
      // R12: software starts the controller
      cmd_wr = 1; cmd_run = 1; tick("R12 run load");
      // R10 R11: ioc completion, masked interrupt
      td_done = 1; td_ioc = 1; tick("R10 ioc sets bit0, masked irq R11");
      ien_xfer = 1; tick("R11 enabled irq");
      wr(16'h0000); tick("R3 zero write keeps bits");
      wr(16'h0001); tick("R3 clear bit0");
      // R10: short packet without spd ignored, with spd sets
      td_done = 1; td_short = 1; tick("R10 short no spd ignored");
      td_done = 1; td_short = 1; td_spd = 1; tick("R10 short with spd");
      wr(16'h0001); tick("R3 clear bit0 again");
      // R9: error with ioc sets both
      td_done = 1; td_err = 1; td_ioc = 1; tick("R9 err+ioc both bits");
      ien_err = 1; wr(16'h0003); tick("R3 clear both");
      td_done = 1; td_err = 1; tick("R9 err alone");
      // R4: set and clear same edge
      td_done = 1; td_err = 1; wr(16'h0002); tick("R4 set wins");
      wr(16'h0002); tick("R3 clear bit1");
      // R8: resume gated by global suspend
      resume_seen = 1; tick("R8 resume ignored without suspend");
      cmd_gsusp = 1; resume_seen = 1; tick("R8 resume latched in suspend");
      ien_resume = 1; tick("R11 resume enable");
      cmd_gsusp = 0; wr(16'h0004); tick("R3 clear resume");
      // R7: bus error stops, unmaskable irq
      ien_xfer = 0; ien_err = 0; ien_resume = 0;
      sysbus_fault = 1; tick("R7 bus fault stops");
      core_idle = 1; tick("R5 halted follows stop");
      tick("R5 halted held");
      wr(16'h0020); tick("R4 halt set beats clear while stopped");
      // R12 R6: fatal beats concurrent run write
      wr(16'h0008); cmd_wr = 1; cmd_run = 1; desc_fault = 1;
      tick("R6 R12 fatal beats run write");
      wr(16'h0010); tick("R3 clear bit4");
      core_idle = 0; cmd_wr = 1; cmd_run = 1; tick("R12 restart");
      wr(16'h0020); tick("R5 clear halted while running");
      core_idle = 1; tick("R5 stays clear while running");
      tick("R5 still clear");
      cmd_wr = 1; cmd_run = 0; tick("R12 software stop");
      tick("R5 halted after software stop");
      wr(16'hFFC0); tick("R2 reserved write no effect");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule